// File: doc/BRIEF.md
# Three-Wire Synthesizer Configuration Receiver

This block takes configuration for a dual-channel frequency synthesizer over three wires: a serial data line, a serial clock and a load strobe. All three are treated as level signals sampled by the system clock `clk`. A rising edge of the serial clock moves one data bit into a 23-bit shift register, most significant bit first. A rising edge of the load strobe copies the assembled word into one of four latch groups.

The two lowest word bits choose the group. Bit 0 picks the channel (0 = channel 1 at index 0, 1 = channel 2 at index 1). Bit 1 picks the kind of word (0 = reference word, 1 = counter word). A reference word sets the reference division ratio, the charge-pump current select and two test bits. A counter word sets the swallow count, the main count, the prescaler modulus select and the phase-detector polarity. It also sets the lock-output select, which is one bit shared by both channels.

A reference ratio below 3 cannot be used. Such a word is dropped as a whole, and the previous contents of that reference group are kept.

Top module: `sp3w_prog_if`

## Requirements
- R1: After reset, both channels read reference ratio 3, main count 3, swallow count 0, and charge-pump select, test bits, prescaler select, polarity and lock select all 0.
- R2: Each rising edge of `ser_clk` seen while `ser_le` is low shifts `ser_data` into bit 0 and moves every other bit up by one. After 23 edges, the first bit sent sits in bit 22.
- R3: On a load, word bit 0 selects the channel and word bit 1 selects reference (0) or counter (1). Only the selected group changes.
- R4: Counter word layout: bit 2 lock select, bit 3 prescaler select, bit 4 polarity, bits 5..11 swallow count, bits 12..22 main count.
- R5: Reference word layout: bits 2..3 test bits (bit 2 is test bit 0), bits 4..17 reference ratio, bit 18 charge-pump select (1 = high current), bits 19..22 ignored.
- R6: A reference word whose ratio field is below 3 changes nothing. The ratio, charge-pump select and test bits of that channel keep their previous values.
- R7: Rising edges of `ser_clk` while `ser_le` is high do not change the shift register.
- R8: `lock_sel` is written by a counter word for either channel and by no reference word.
- R9: Outputs change only on a rising edge of `ser_le`. Shifting without a load, or holding `ser_le` high, changes no output.
- R10: Latched outputs change at the first `clk` rising edge that samples `ser_le` high after a low sample. Before that edge they hold their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all serial inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial shift clock (level, edge detected) |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; rising edge latches the word |
| ref_ratio | output | 2x14 | Reference division ratio per channel |
| cp_hi | output | 2 | Charge-pump high-current select per channel |
| test_bits | output | 2x2 | Test bits per channel |
| swallow_cnt | output | 2x7 | Swallow count per channel |
| main_cnt | output | 2x11 | Main count per channel |
| psc_sel | output | 2 | Prescaler modulus select per channel |
| pd_invert | output | 2 | Phase-detector polarity per channel |
| lock_sel | output | 1 | Shared lock-output select |

## Verification
A shift takes effect at the `clk` edge that first samples `ser_clk` high. A load appears on the outputs right after the `clk` edge that first samples `ser_le` high, so the outputs lag the strobe by exactly one edge. The bench changes every input on a falling edge of `clk`. It compares outputs on the next falling edge after the loading rising edge, and for R10 it also samples the old values in the half cycle before that edge. Sweeps cover every swallow count, a spread of main counts and reference ratios, all four destinations, and the rejected ratios 0 to 2.

// File: rtl/sp3w_pkg.sv
package sp3w_pkg;
  parameter int WORD_W  = 23;
  parameter int REF_W   = 14;
  parameter int A_W     = 7;
  parameter int N_W     = 11;
  parameter int NCH     = 2;
  parameter int MIN_REF = 3;
  parameter int RST_N   = 3;

  // word layout (bit 0 = last bit shifted in)
  localparam int CN_CH   = 0;
  localparam int CN_KIND = 1;
  localparam int T_LO    = 2;
  localparam int R_LO    = T_LO + 2;
  localparam int CS_BIT  = R_LO + REF_W;
  localparam int LDS_BIT = 2;
  localparam int SW_BIT  = 3;
  localparam int FC_BIT  = 4;
  localparam int A_LO    = 5;
  localparam int N_LO    = A_LO + A_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic [REF_W-1:0] ratio;
    logic             cp_hi;
    logic [1:0]       test;
  } ref_img_t;

  typedef struct packed {
    logic [N_W-1:0] main;
    logic [A_W-1:0] swallow;
    logic           psc;
    logic           pol;
  } cnt_img_t;

  function automatic ref_img_t ref_fields(word_t w);
    ref_img_t r;
    r.ratio = w[R_LO +: REF_W];
    r.cp_hi = w[CS_BIT];
    r.test  = w[T_LO +: 2];
    return r;
  endfunction

  function automatic cnt_img_t cnt_fields(word_t w);
    cnt_img_t c;
    c.main    = w[N_LO +: N_W];
    c.swallow = w[A_LO +: A_W];
    c.psc     = w[SW_BIT];
    c.pol     = w[FC_BIT];
    return c;
  endfunction

  function automatic logic ratio_legal(logic [REF_W-1:0] r);
    return r >= REF_W'(MIN_REF);
  endfunction

  function automatic logic word_for_chan(word_t w, logic ch);
    return w[CN_CH] == ch;
  endfunction

  function automatic logic word_is_counter(word_t w);
    return w[CN_KIND];
  endfunction
endpackage

// File: rtl/sp3w_rise.sv
module sp3w_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/sp3w_shifter.sv
module sp3w_shifter
  import sp3w_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  shift_en,
  input  logic  bit_in,
  output word_t word
);
  always_ff @(posedge clk) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[WORD_W-2:0], bit_in};
  end

  // R2: one new bit enters at the bottom, the rest move up by one
  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (word == {$past(word[WORD_W-2:0]), $past(bit_in)}));
endmodule

// File: rtl/sp3w_chan.sv
module sp3w_chan
  import sp3w_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_evt,
  input  word_t    word,
  output ref_img_t ref_q,
  output cnt_img_t cnt_q,
  output logic     ref_reject
);
  localparam logic CH_BIT = 1'(CH);

  logic hit_ref, hit_cnt, ref_wr;

  assign hit_ref    = load_evt && word_for_chan(word, CH_BIT) && !word_is_counter(word);
  assign hit_cnt    = load_evt && word_for_chan(word, CH_BIT) &&  word_is_counter(word);
  assign ref_reject = hit_ref && !ratio_legal(word[R_LO +: REF_W]);
  assign ref_wr     = hit_ref && !ref_reject;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q.ratio <= REF_W'(MIN_REF);
      ref_q.cp_hi <= 1'b0;
      ref_q.test  <= 2'b00;
    end else if (ref_wr) begin
      ref_q <= ref_fields(word);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q.main    <= N_W'(RST_N);
      cnt_q.swallow <= '0;
      cnt_q.psc     <= 1'b0;
      cnt_q.pol     <= 1'b0;
    end else if (hit_cnt) begin
      cnt_q <= cnt_fields(word);
    end
  end

  // R6: a rejected reference word leaves the group untouched
  p_reject_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_reject |=> $stable(ref_q));

  // R6: the latched ratio never falls below the floor
  p_ratio_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_q.ratio >= REF_W'(MIN_REF));

  // R3: counter group moves only when addressed
  p_cnt_routed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_cnt |=> $stable(cnt_q));
endmodule

// File: rtl/sp3w_prog_if.sv
module sp3w_prog_if
  import sp3w_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ser_clk,
  input  logic                      ser_data,
  input  logic                      ser_le,
  output logic [NCH-1:0][REF_W-1:0] ref_ratio,
  output logic [NCH-1:0]            cp_hi,
  output logic [NCH-1:0][1:0]       test_bits,
  output logic [NCH-1:0][A_W-1:0]   swallow_cnt,
  output logic [NCH-1:0][N_W-1:0]   main_cnt,
  output logic [NCH-1:0]            psc_sel,
  output logic [NCH-1:0]            pd_invert,
  output logic                      lock_sel
);
  logic     sclk_rise, load_evt, shift_evt;
  word_t    shreg;
  ref_img_t ref_img [NCH];
  cnt_img_t cnt_img [NCH];
  logic [NCH-1:0] ref_rej;

  sp3w_rise u_sclk_edge (.clk(clk), .rst_n(rst_n), .lvl(ser_clk), .rise(sclk_rise));
  sp3w_rise u_le_edge   (.clk(clk), .rst_n(rst_n), .lvl(ser_le),  .rise(load_evt));

  assign shift_evt = sclk_rise && !ser_le;

  sp3w_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_evt), .bit_in(ser_data), .word(shreg)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sp3w_chan #(.CH(c)) u_ch (
      .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .word(shreg),
      .ref_q(ref_img[c]), .cnt_q(cnt_img[c]), .ref_reject(ref_rej[c])
    );
    assign ref_ratio[c]   = ref_img[c].ratio;
    assign cp_hi[c]       = ref_img[c].cp_hi;
    assign test_bits[c]   = ref_img[c].test;
    assign swallow_cnt[c] = cnt_img[c].swallow;
    assign main_cnt[c]    = cnt_img[c].main;
    assign psc_sel[c]     = cnt_img[c].psc;
    assign pd_invert[c]   = cnt_img[c].pol;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                   lock_sel <= 1'b0;
    else if (load_evt && word_is_counter(shreg))  lock_sel <= shreg[LDS_BIT];
  end

  // R7: clock edges during a high strobe leave the register alone
  p_no_shift_le_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && ser_le) |=> $stable(shreg));

  // R9: no strobe edge, no output change
  p_hold_no_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> ($stable(ref_ratio) && $stable(main_cnt) && $stable(swallow_cnt)
                   && $stable(cp_hi) && $stable(lock_sel)));

  // R8: the shared select moves only after a counter-word load
  p_lock_sel_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lock_sel) |-> $past(load_evt && shreg[CN_KIND]));

  // R3: at most one reference group may reject per load
  p_single_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ref_rej));
endmodule

// File: tb/sp3w_prog_if_tb_top.sv
module sp3w_prog_if_tb_top;
  import sp3w_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [NCH-1:0][REF_W-1:0] ref_ratio;
  logic [NCH-1:0]            cp_hi;
  logic [NCH-1:0][1:0]       test_bits;
  logic [NCH-1:0][A_W-1:0]   swallow_cnt;
  logic [NCH-1:0][N_W-1:0]   main_cnt;
  logic [NCH-1:0]            psc_sel;
  logic [NCH-1:0]            pd_invert;
  logic                      lock_sel;

  int errors = 0, checks = 0;
  int e_ratio[2], e_cp[2], e_test[2], e_a[2], e_n[2], e_sw[2], e_fc[2];
  int e_lds;

  always #2 clk = ~clk;

  sp3w_prog_if dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .ref_ratio(ref_ratio), .cp_hi(cp_hi), .test_bits(test_bits), .swallow_cnt(swallow_cnt),
    .main_cnt(main_cnt), .psc_sel(psc_sel), .pd_invert(pd_invert), .lock_sel(lock_sel)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int c = 0; c < 2; c++) begin
      chk(req, $sformatf("ch%0d ratio", c), int'(ref_ratio[c]), e_ratio[c]);
      chk(req, $sformatf("ch%0d cp", c), int'(cp_hi[c]), e_cp[c]);
      chk(req, $sformatf("ch%0d test", c), int'(test_bits[c]), e_test[c]);
      chk(req, $sformatf("ch%0d swallow", c), int'(swallow_cnt[c]), e_a[c]);
      chk(req, $sformatf("ch%0d main", c), int'(main_cnt[c]), e_n[c]);
      chk(req, $sformatf("ch%0d psc", c), int'(psc_sel[c]), e_sw[c]);
      chk(req, $sformatf("ch%0d pol", c), int'(pd_invert[c]), e_fc[c]);
    end
    chk(req, "lock_sel", int'(lock_sel), e_lds);
  endtask

  function automatic int unsigned mk_ref(int ch, int ratio, int cp, int tst, int junk);
    return ch + tst * 4 + ratio * 16 + cp * 262144 + junk * 524288;
  endfunction

  function automatic int unsigned mk_cnt(int ch, int lds, int sw, int fc, int a, int n);
    return ch + 2 + lds * 4 + sw * 8 + fc * 16 + a * 32 + n * 4096;
  endfunction

  task automatic model_apply(int unsigned v);
    int ch, r;
    ch = v % 2;
    if ((v / 2) % 2 == 0) begin
      r = (v / 16) % 16384;
      if (r >= 3) begin
        e_ratio[ch] = r;
        e_test[ch]  = (v / 4) % 4;
        e_cp[ch]    = (v / 262144) % 2;
      end
    end else begin
      e_lds     = (v / 4) % 2;
      e_sw[ch]  = (v / 8) % 2;
      e_fc[ch]  = (v / 16) % 2;
      e_a[ch]   = (v / 32) % 128;
      e_n[ch]   = (v / 4096) % 2048;
    end
  endtask

  // R2: MSB first, one bit per serial clock rise
  task automatic send_bits(int unsigned v);
    for (int i = 22; i >= 0; i--) begin
      tick(); ser_data = v[i];
      tick(); ser_clk = 1'b1;
      tick(); ser_clk = 1'b0;
    end
  endtask

  task automatic pulse_le();
    tick(); ser_le = 1'b1;
    tick(); ser_le = 1'b0;
  endtask

  task automatic load_word(int unsigned v);
    send_bits(v);
    pulse_le();
    model_apply(v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      e_ratio[c] = 3; e_cp[c] = 0; e_test[c] = 0; e_a[c] = 0;
      e_n[c] = 3; e_sw[c] = 0; e_fc[c] = 0;
    end
    e_lds = 0;
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    check_all("R1");

    // R5: reference fields, junk bits set
    for (int k = 0; k < 6; k++) begin
      for (int c = 0; c < 2; c++) begin
        load_word(mk_ref(c, 3 + k * 3277 + c * 5, (k + c) % 2, (k + 2 * c) % 4, (k * 5 + 3) % 16));
        check_all("R5");
      end
    end
    load_word(mk_ref(1, 16383, 1, 3, 15));
    check_all("R5");

    // R6: ratios below the floor are dropped whole
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < 2; c++) begin
        load_word(mk_ref(c, r, 1 - e_cp[c], (e_test[c] + 1) % 4, 0));
        check_all("R6");
      end
    end
    load_word(mk_ref(0, 3, 1, 2, 0));
    check_all("R6");

    // R4 and R8: full swallow sweep, alternating channels
    for (int a = 0; a < 128; a++) begin
      load_word(mk_cnt(a % 2, (a / 2) % 2, (a / 4) % 2, (a / 8) % 2, a, ((a * 37) % 2045) + 3));
      check_all("R4");
    end
    load_word(mk_cnt(1, 1, 1, 1, 127, 2047));
    check_all("R8");
    load_word(mk_ref(0, 77, 0, 1, 0));
    check_all("R8");

    // R3: each destination in turn, others must not move
    for (int d = 0; d < 4; d++) begin
      if (d / 2 == 0) load_word(mk_ref(d % 2, 1000 + d, 1, d, 0));
      else            load_word(mk_cnt(d % 2, 0, 0, 1, 10 + d, 500 + d));
      check_all("R3");
    end

    // R9: a word shifted without a strobe changes nothing
    send_bits(mk_cnt(0, 1, 1, 1, 99, 999));
    tick();
    check_all("R9");
    tick(); ser_le = 1'b1;
    repeat (6) tick();
    model_apply(mk_cnt(0, 1, 1, 1, 99, 999));
    check_all("R9");
    ser_le = 1'b0;

    // R7: shifting with the strobe high is ignored
    load_word(mk_ref(0, 1234, 0, 2, 0));
    tick(); ser_le = 1'b1;
    for (int i = 22; i >= 0; i--) begin
      tick(); ser_data = mk_cnt(1, 0, 1, 0, 55, 1555) >> i;
      tick(); ser_clk = 1'b1;
      tick(); ser_clk = 1'b0;
    end
    tick(); ser_le = 1'b0;
    pulse_le();
    check_all("R7");

    // R10: outputs hold until the edge that samples the strobe
    send_bits(mk_ref(1, 4321, 1, 1, 0));
    tick(); ser_le = 1'b1;
    check_all("R10");
    tick();
    model_apply(mk_ref(1, 4321, 1, 1, 0));
    check_all("R10");
    ser_le = 1'b0;
    tick();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule